// File: doc/BRIEF.md
# Processor Status Word Unit

This block holds the status word of a small 16-bit processor and keeps it up to date. Five arithmetic indications (sign, zero, parity, half-carry and carry) are written from a result that the ALU offers over a valid/ready stream. Three control bits (string step direction, maskable-interrupt enable and single-step trace) change only through a 3-bit command input. A few single-cycle commands also act on the carry bit.

For interrupt handling, the word on `flags` during the cycle that `entry` is high is the value to push. That value still has trace set if trace was on. Trace then clears on the following edge. A `restore` strobe reloads every flag from `restore_word`, including trace, so that a trace handler can resume single-stepping when it returns.

Only one source writes the word in a given cycle. When a restore, an entry or a command is active, `alu_ready` drops. The ALU must then hold `alu_valid`, `alu_result`, `alu_word`, `alu_carry` and `alu_half` unchanged until a cycle in which `alu_ready` is high. A transfer takes place on a rising edge where both `alu_valid` and `alu_ready` are high.

Top module: `psw_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `flags` reads 0x0002, `step_down` is 0 and `irq_take` is 0.
- R2: The word has this layout: carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7, trace at bit 8, interrupt enable at bit 9 and direction at bit 10. Bit 1 always reads 1. Bits 3, 5 and 11 to 15 always read 0, whatever value a restore writes to them.
- R3: On an accepted update with `alu_word`=1, sign takes `alu_result[15]` and zero is set only when all 16 bits are 0. With `alu_word`=0, sign takes bit 7 and zero tests only `alu_result[7:0]`.
- R4: On an accepted update, parity is set when `alu_result[7:0]` holds an even number of ones, in either size mode.
- R5: On an accepted update, carry and half-carry take `alu_carry` and `alu_half`. The arithmetic bits change on no other cycle. An update never alters the three control bits.
- R6: `cmd` takes effect on the next edge. The encodings are: 0 no action, 1 clear carry, 2 set carry, 3 complement carry, 4 clear direction, 5 set direction, 6 clear interrupt enable, 7 set interrupt enable.
- R7: `step_down` equals the direction bit, so 1 means the string indices count down. `irq_take` is `irq_req` gated by the interrupt-enable bit.
- R8: In the cycle `entry` is high, `flags` still shows the previous word with trace unchanged. After that edge, trace is 0 and every other bit is unchanged.
- R9: After a `restore` edge, all eight flag bits equal the corresponding bits of `restore_word`.
- R10: The priority order is restore, then entry, then a non-zero command, then the ALU. Lower sources active in the same cycle have no effect. `alu_ready` is 0 whenever restore, entry or a non-zero command is active.
- R11: `alu_ready` is 1 in every cycle out of reset with no restore, entry or command. An update that was held off is taken on the first such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_valid | input | 1 | ALU offers a result |
| alu_ready | output | 1 | Unit accepts the result this cycle |
| alu_result | input | DATA_W | ALU result |
| alu_word | input | 1 | 1 = full-width operation, 0 = byte |
| alu_carry | input | 1 | Carry/borrow out of the top bit |
| alu_half | input | 1 | Carry/borrow across the low nibble |
| cmd | input | 3 | Flag command, encoding in R6 |
| entry | input | 1 | Interrupt-entry strobe |
| restore | input | 1 | Reload strobe |
| restore_word | input | 16 | Word popped on return |
| irq_req | input | 1 | Maskable interrupt request |
| flags | output | 16 | Status word |
| step_down | output | 1 | String index direction, 1 = decrement |
| irq_take | output | 1 | Maskable request accepted |

## Verification
The bench builds the unit with DATA_W=16 and BYTE_W=8. With these values the byte-mode sign bit (bit 7) and the word-mode sign bit (bit 15) are different bits. The values also allow a result with a zero low byte and a non-zero high byte, so zero detection in byte mode and in word mode give different answers. Parity always covers the same low byte in both modes, so an operand that is odd over the whole word but even over its low byte exposes any parity computed too wide.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W    = 16;
  localparam int POS_CARRY = 0;
  localparam int POS_PAR   = 2;
  localparam int POS_HALF  = 4;
  localparam int POS_ZERO  = 6;
  localparam int POS_SIGN  = 7;
  localparam int POS_TRACE = 8;
  localparam int POS_IEN   = 9;
  localparam int POS_DIR   = 10;

  // bits that read as constant 1
  localparam logic [WORD_W-1:0] FIXED_ONES = 16'h0002;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_CARRY_CLR = 3'd1,
    CMD_CARRY_SET = 3'd2,
    CMD_CARRY_TOG = 3'd3,
    CMD_DIR_CLR   = 3'd4,
    CMD_DIR_SET   = 3'd5,
    CMD_IEN_CLR   = 3'd6,
    CMD_IEN_SET   = 3'd7
  } flag_cmd_e;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trace;
    logic sign;
    logic zero;
    logic half;
    logic parity;
    logic carry;
  } flag_s;

  function automatic flag_s unpack_word(input logic [WORD_W-1:0] w);
    flag_s f;
    f.carry  = w[POS_CARRY];
    f.parity = w[POS_PAR];
    f.half   = w[POS_HALF];
    f.zero   = w[POS_ZERO];
    f.sign   = w[POS_SIGN];
    f.trace  = w[POS_TRACE];
    f.ien    = w[POS_IEN];
    f.dir    = w[POS_DIR];
    return f;
  endfunction
endpackage

// File: rtl/psw_arith.sv
module psw_arith #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              word_mode,
  input  logic              carry_in,
  input  logic              half_in,
  output logic              sign,
  output logic              zero,
  output logic              parity,
  output logic              carry,
  output logic              half
);
  localparam int LOW_MSB = BYTE_W - 1;
  localparam int TOP_MSB = DATA_W - 1;

  logic low_zero;
  logic full_zero;

  assign low_zero  = (result[LOW_MSB:0] == '0);
  assign full_zero = (result == '0);

  assign sign   = word_mode ? result[TOP_MSB] : result[LOW_MSB];
  assign zero   = word_mode ? full_zero : low_zero;
  assign parity = ~^result[LOW_MSB:0];
  assign carry  = carry_in;
  assign half   = half_in;
endmodule

// File: rtl/psw_next.sv
module psw_next
  import psw_pkg::*;
(
  input  flag_s      cur,
  input  logic       restore,
  input  flag_s      rest_f,
  input  logic       entry,
  input  logic [2:0] cmd,
  input  logic       alu_valid,
  input  logic       a_sign,
  input  logic       a_zero,
  input  logic       a_parity,
  input  logic       a_carry,
  input  logic       a_half,
  output flag_s      nxt,
  output logic       busy
);
  flag_cmd_e op;

  assign op   = flag_cmd_e'(cmd);
  assign busy = restore | entry | (op != CMD_NONE);

  always_comb begin
    nxt = cur;
    if (restore) begin
      nxt = rest_f;
    end else if (entry) begin
      nxt.trace = 1'b0;
    end else if (op != CMD_NONE) begin
      case (op)
        CMD_CARRY_CLR: nxt.carry = 1'b0;
        CMD_CARRY_SET: nxt.carry = 1'b1;
        CMD_CARRY_TOG: nxt.carry = ~cur.carry;
        CMD_DIR_CLR:   nxt.dir   = 1'b0;
        CMD_DIR_SET:   nxt.dir   = 1'b1;
        CMD_IEN_CLR:   nxt.ien   = 1'b0;
        CMD_IEN_SET:   nxt.ien   = 1'b1;
        default:       nxt       = cur;
      endcase
    end else if (alu_valid) begin
      nxt.sign   = a_sign;
      nxt.zero   = a_zero;
      nxt.parity = a_parity;
      nxt.carry  = a_carry;
      nxt.half   = a_half;
    end
  end
endmodule

// File: rtl/psw_pack.sv
module psw_pack
  import psw_pkg::*;
(
  input  flag_s              f,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word             = FIXED_ONES;
    word[POS_CARRY]  = f.carry;
    word[POS_PAR]    = f.parity;
    word[POS_HALF]   = f.half;
    word[POS_ZERO]   = f.zero;
    word[POS_SIGN]   = f.sign;
    word[POS_TRACE]  = f.trace;
    word[POS_IEN]    = f.ien;
    word[POS_DIR]    = f.dir;
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  output logic              alu_ready,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_word,
  input  logic              alu_carry,
  input  logic              alu_half,
  input  logic [2:0]        cmd,
  input  logic              entry,
  input  logic              restore,
  input  logic [15:0]       restore_word,
  input  logic              irq_req,
  output logic [15:0]       flags,
  output logic              step_down,
  output logic              irq_take
);
  flag_s cur_q;
  flag_s nxt;
  flag_s rest_f;
  logic  busy;
  logic  a_sign, a_zero, a_parity, a_carry, a_half;

  assign rest_f = unpack_word(restore_word);

  psw_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_arith (
    .result    (alu_result),
    .word_mode (alu_word),
    .carry_in  (alu_carry),
    .half_in   (alu_half),
    .sign      (a_sign),
    .zero      (a_zero),
    .parity    (a_parity),
    .carry     (a_carry),
    .half      (a_half)
  );

  psw_next u_next (
    .cur       (cur_q),
    .restore   (restore),
    .rest_f    (rest_f),
    .entry     (entry),
    .cmd       (cmd),
    .alu_valid (alu_valid),
    .a_sign    (a_sign),
    .a_zero    (a_zero),
    .a_parity  (a_parity),
    .a_carry   (a_carry),
    .a_half    (a_half),
    .nxt       (nxt),
    .busy      (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  psw_pack u_pack (
    .f    (cur_q),
    .word (flags)
  );

  assign alu_ready = ~busy;
  assign step_down = cur_q.dir;
  assign irq_take  = irq_req & cur_q.ien;
endmodule

// File: rtl/psw_chk.sv
module psw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        alu_valid,
  input logic        alu_ready,
  input logic [2:0]  cmd,
  input logic        entry,
  input logic        restore,
  input logic [15:0] restore_word,
  input logic        irq_req,
  input logic [15:0] flags,
  input logic        irq_take
);
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !flags[3] && !flags[5] && (flags[15:11] == 5'd0)); // R2

  AST_ENTRY_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !restore) |=> !flags[8]); // R8

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (flags[10:6] == $past(restore_word[10:6])) &&
                (flags[4] == $past(restore_word[4])) &&
                (flags[2] == $past(restore_word[2])) &&
                (flags[0] == $past(restore_word[0]))); // R9

  AST_READY_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (restore || entry || (cmd != 3'd0)) |-> !alu_ready); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !entry && (cmd == 3'd0) && !(alu_valid && alu_ready)) |=> $stable(flags)); // R5

  AST_CARRY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'd3) && !restore && !entry) |=> (flags[0] != $past(flags[0]))); // R6

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_req && flags[9])); // R7
endmodule

bind psw_unit psw_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alu_valid    (alu_valid),
  .alu_ready    (alu_ready),
  .cmd          (cmd),
  .entry        (entry),
  .restore      (restore),
  .restore_word (restore_word),
  .irq_req      (irq_req),
  .flags        (flags),
  .irq_take     (irq_take)
);

// File: tb/tb_psw_unit.sv
`timescale 1ns/1ps
module tb_psw_unit;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam real CLK_PERIOD = 8.0;
  localparam int NVEC = 8;

  // {word, carry, half, result[15:0], expected flags[15:0]}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 16'h0000, 16'h0046},
    {1'b1, 1'b1, 1'b0, 16'h8001, 16'h0083},
    {1'b0, 1'b0, 1'b1, 16'h1280, 16'h0092},
    {1'b0, 1'b1, 1'b1, 16'hFF00, 16'h0057},
    {1'b1, 1'b0, 1'b0, 16'h00FF, 16'h0006},
    {1'b1, 1'b0, 1'b1, 16'h7F03, 16'h0016},
    {1'b0, 1'b0, 1'b0, 16'h0007, 16'h0002},
    {1'b1, 1'b1, 1'b0, 16'hFFFE, 16'h0083}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alu_valid;
  logic              alu_ready;
  logic [DATA_W-1:0] alu_result;
  logic              alu_word;
  logic              alu_carry;
  logic              alu_half;
  logic [2:0]        cmd;
  logic              entry;
  logic              restore;
  logic [15:0]       restore_word;
  logic              irq_req;
  logic [15:0]       flags;
  logic              step_down;
  logic              irq_take;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) dut (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_ready(alu_ready),
    .alu_result(alu_result), .alu_word(alu_word), .alu_carry(alu_carry),
    .alu_half(alu_half), .cmd(cmd), .entry(entry), .restore(restore),
    .restore_word(restore_word), .irq_req(irq_req), .flags(flags),
    .step_down(step_down), .irq_take(irq_take)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [2:0] c);
    cmd = c;
    step();
    cmd = 3'd0;
  endtask

  task automatic do_restore(input logic [15:0] w);
    restore = 1'b1;
    restore_word = w;
    step();
    restore = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alu_valid = 1'b0; alu_result = '0; alu_word = 1'b0;
    alu_carry = 1'b0; alu_half = 1'b0; cmd = 3'd0; entry = 1'b0;
    restore = 1'b0; restore_word = '0; irq_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", flags, 16'h0002);
    chk("R1 step_down in reset", {15'd0, step_down}, 16'd0);
    chk("R1 irq_take in reset", {15'd0, irq_take}, 16'd0);
    rst_n = 1'b1;
    irq_req = 1'b0;
    step();
    chk("R1 flags after release", flags, 16'h0002);
    chk("R11 ready when idle", {15'd0, alu_ready}, 16'd1);

    // R3 R4 R5: vector table
    for (int i = 0; i < NVEC; i++) begin
      alu_valid  = 1'b1;
      alu_word   = VEC[i][34];
      alu_carry  = VEC[i][33];
      alu_half   = VEC[i][32];
      alu_result = VEC[i][31:16];
      step();
      alu_valid = 1'b0;
      chk($sformatf("R3/R4/R5 vector %0d", i), flags, VEC[i][15:0]);
    end

    // R5: no valid -> no change
    alu_result = 16'h0000; alu_word = 1'b1; alu_carry = 1'b0; alu_half = 1'b1;
    step();
    chk("R5 no update without valid", flags, 16'h0083);

    // R6 commands
    do_cmd(3'd1); chk("R6 clear carry", flags, 16'h0082);
    do_cmd(3'd2); chk("R6 set carry", flags, 16'h0083);
    do_cmd(3'd3); chk("R6 toggle carry to 0", flags, 16'h0082);
    do_cmd(3'd3); chk("R6 toggle carry to 1", flags, 16'h0083);
    do_cmd(3'd5); chk("R6 set direction", flags, 16'h0483);
    chk("R7 step_down follows direction", {15'd0, step_down}, 16'd1);
    do_cmd(3'd7); chk("R6 set irq enable", flags, 16'h0683);
    irq_req = 1'b1; #1;
    chk("R7 irq_take when enabled", {15'd0, irq_take}, 16'd1);
    do_cmd(3'd6); chk("R6 clear irq enable", flags, 16'h0483);
    chk("R7 irq_take masked", {15'd0, irq_take}, 16'd0);
    irq_req = 1'b0;
    do_cmd(3'd4); chk("R6 clear direction", flags, 16'h0083);
    chk("R7 step_down up", {15'd0, step_down}, 16'd0);

    // R10 command beats ALU; R11 held update taken later
    alu_valid = 1'b1; alu_result = 16'h0000; alu_word = 1'b1;
    alu_carry = 1'b0; alu_half = 1'b0; cmd = 3'd1; #1;
    chk("R10 ready low under command", {15'd0, alu_ready}, 16'd0);
    step();
    cmd = 3'd0;
    chk("R10 ALU ignored during command", flags, 16'h0082);
    #1;
    chk("R11 ready returns", {15'd0, alu_ready}, 16'd1);
    step();
    alu_valid = 1'b0;
    chk("R11 held update accepted", flags, 16'h0046);

    // R9 R2 restore
    do_restore(16'hFFFF);
    chk("R9 restore all ones", flags, 16'h07D7);

    // R8 entry
    entry = 1'b1; #1;
    chk("R8 trace visible during entry", flags, 16'h07D7);
    step();
    entry = 1'b0;
    chk("R8 trace cleared after entry", flags, 16'h06D7);

    do_restore(16'h0100);
    chk("R9 restore brings trace back", flags, 16'h0102);

    // R10 priority cases
    entry = 1'b1;
    do_restore(16'h0500);
    entry = 1'b0;
    chk("R10 restore beats entry", flags, 16'h0502);

    entry = 1'b1; cmd = 3'd2;
    step();
    entry = 1'b0; cmd = 3'd0;
    chk("R10 entry beats command", flags, 16'h0402);

    alu_valid = 1'b1; alu_result = 16'h8000; alu_word = 1'b1; alu_carry = 1'b1;
    restore = 1'b1; restore_word = 16'h0000; #1;
    chk("R10 ready low under restore", {15'd0, alu_ready}, 16'd0);
    step();
    restore = 1'b0; alu_valid = 1'b0;
    chk("R10 restore beats ALU", flags, 16'h0002);

    // R2 reserved bits ignored on restore
    do_restore(16'hF82A);
    chk("R2 reserved bits fixed", flags, 16'h0002);

    // R1 reset mid-run
    do_cmd(3'd5);
    rst_n = 1'b0; #1;
    chk("R1 async reset", flags, 16'h0002);
    chk("R1 step_down after reset", {15'd0, step_down}, 16'd0);
    step();
    rst_n = 1'b1;
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule